// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Model

This block is a synthesizable, cycle-accurate model of a small static memory with independent read and write ports and a fixed burst of four words. The whole model runs on one clock. A double-rate data beat is shown as two half-words that share one clock cycle: the half-word that belongs to the rising edge and the half-word that belongs to the falling edge. So a four-word burst takes two clock cycles on each port.

A read and a write are requested on the same rising edge. Each has its own active-low select, and both use one shared burst address. Word k of a burst lives at the location base + k. Write data comes with active-low byte enables on every beat. Read data comes out two cycles after the request, together with a data-valid flag, an output-enable flag and a two-bit echo-phase code.

When a read and a write to the same address are taken in the same cycle, the read returns the new write data. After reset the model accepts no request until a lock counter has run out.

Top module: `qdr_burst_sram`

## Requirements
- R1: `ready` stays low for exactly LOCK_CYC rising edges after reset is released, and then stays high. While `ready` is low, requests on either port are ignored and no read data is produced.
- R2: During and straight after reset, `rq_oe` and `rq_valid` are 0, `rq_r` and `rq_f` are all zero, and `echo_ph` is 2'b00.
- R3: A read is taken on an edge where `rd_n` is low. Two cycles after that edge, `rq_r` and `rq_f` carry words base+0 and base+1. In the following cycle they carry base+2 and base+3.
- R4: A write is taken on an edge where `wr_n` is low. At that edge, `wd_r` and `wd_f` supply words base+0 and base+1. At the next edge they supply base+2 and base+3.
- R5: Byte-enable bit 0 covers word bits 8:0 and bit 1 covers bits 17:9. A 0 writes that byte of that beat, and a 1 leaves the stored byte unchanged. `be_r_n` goes with `wd_r` and `be_f_n` goes with `wd_f`.
- R6: A request on a port in the cycle right after that same port accepted a request is ignored. Its address and data have no effect.
- R7: A read of the address written in the same cycle, or during the second cycle of that write, returns the newly written bytes merged with the old content of masked bytes, beat for beat.
- R8: `rq_oe` and `rq_valid` are high in exactly the two cycles of each read burst and low otherwise. While `rq_oe` is low, the data outputs are zero.
- R9: `echo_ph` is 2'b10 (high in the rising half, low in the falling half) in every cycle that read data is driven, and 2'b00 otherwise.
- R10: Reads accepted every second cycle produce an unbroken stream: `rq_oe` stays high across the joins between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read request select |
| wr_n | input | 1 | Active-low write request select |
| addr | input | ADDR_W | Shared burst address |
| wd_r | input | WORD_W | Write half-word for the rising edge |
| wd_f | input | WORD_W | Write half-word for the falling edge |
| be_r_n | input | BYTES | Active-low byte enables for `wd_r` |
| be_f_n | input | BYTES | Active-low byte enables for `wd_f` |
| ready | output | 1 | Lock period over, requests accepted |
| rq_r | output | WORD_W | Read half-word for the rising edge |
| rq_f | output | WORD_W | Read half-word for the falling edge |
| rq_valid | output | 1 | Read data valid |
| rq_oe | output | 1 | Output driven (low means high impedance) |
| echo_ph | output | 2 | Echo-clock level in the rising and falling half |

## Verification
A read and a write can be taken on the same edge. When they name the same address, the read must pick up the write while that write is still being committed. The bench provokes this for every location, driving both selects low together and using byte-enable patterns that keep some old bytes. It also places a read in the second cycle of a write. Each read beat is compared with a bench-side array that applies every write, byte by byte, at the moment the write is issued.

// File: rtl/qbs_pkg.sv
`timescale 1ns/1ps
package qbs_pkg;
   // words per burst; also the number of beats per request
   localparam int unsigned BURST_LEN = 4;
   // two-bit echo level: {rising half, falling half}
   typedef enum logic [1:0] {
      ECHO_IDLE = 2'b00,
      ECHO_RUN  = 2'b10
   } echo_t;
endpackage

// File: rtl/qbs_lock.sv
`timescale 1ns/1ps
module qbs_lock #(
   parameter int unsigned LOCK_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   generate
      if (LOCK_CYC == 0) begin : g_nolock
         assign ready = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LOCK_CYC + 1);
         localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q != LIMIT) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign ready = (cnt_q == LIMIT);

         // once locked, the model never drops ready again
         p_stay_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ready |=> ready);
      end
   endgenerate
endmodule

// File: rtl/qbs_bank.sv
`timescale 1ns/1ps
module qbs_bank #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 18,
   parameter int unsigned BYTES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [BYTES-1:0]  wbe,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              fwd,
   output logic [WORD_W-1:0] rword
);
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned BYTE_W = WORD_W / BYTES;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] old_w;

   // array has no reset: content is undefined until written
   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < int'(BYTES); b++) begin
            if (wbe[b]) begin
               mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
         end
      end
   end

   // a read looking at the location committed on this same edge takes
   // the enabled bytes straight from the commit data
   always_comb begin
      old_w = mem[raddr];
      for (int b = 0; b < int'(BYTES); b++) begin
         rword[b*BYTE_W +: BYTE_W] = (fwd && wbe[b]) ? wdata[b*BYTE_W +: BYTE_W]
                                                    : old_w[b*BYTE_W +: BYTE_W];
      end
   end

   // forwarding is only requested against a live commit of the same location
   p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd |-> (we && (waddr == raddr)));
endmodule

// File: rtl/qbs_wr_port.sv
`timescale 1ns/1ps
module qbs_wr_port #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 18,
   parameter int unsigned BYTES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wd_r,
   input  logic [WORD_W-1:0] wd_f,
   input  logic [BYTES-1:0]  be_r_n,
   input  logic [BYTES-1:0]  be_f_n,
   output logic              cm_we,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [qbs_pkg::BURST_LEN-1:0][WORD_W-1:0] cm_data,
   output logic [qbs_pkg::BURST_LEN-1:0][BYTES-1:0]  cm_be
);
   logic              busy_q;
   logic              wr_go;
   logic [ADDR_W-1:0] wa_q;
   logic [WORD_W-1:0] b0_q, b1_q;
   logic [BYTES-1:0]  m0_q, m1_q;

   // the cycle after an accepted write carries its tail beats
   assign wr_go = ready && !wr_n && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wa_q   <= '0;
         b0_q   <= '0;
         b1_q   <= '0;
         m0_q   <= '0;
         m1_q   <= '0;
      end else begin
         busy_q <= wr_go;
         if (wr_go) begin
            wa_q <= addr;
            b0_q <= wd_r;
            b1_q <= wd_f;
            m0_q <= ~be_r_n;
            m1_q <= ~be_f_n;
         end
      end
   end

   // all four words commit together on the edge that takes the tail beats
   assign cm_we   = busy_q;
   assign cm_addr = wa_q;
   assign cm_data = {wd_f, wd_r, b1_q, b0_q};
   assign cm_be   = {~be_f_n, ~be_r_n, m1_q, m0_q};

   // commits never come on two edges in a row
   p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cm_we |=> !cm_we);
endmodule

// File: rtl/qbs_rd_port.sv
`timescale 1ns/1ps
module qbs_rd_port #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [qbs_pkg::BURST_LEN-1:0][WORD_W-1:0] words,
   output logic              look,
   output logic [ADDR_W-1:0] look_addr,
   output logic [WORD_W-1:0] rq_r,
   output logic [WORD_W-1:0] rq_f,
   output logic              rq_valid,
   output logic              rq_oe,
   output logic [1:0]        echo_ph
);
   logic              rd_go;
   logic              s1_q, s2_q, s3_q;
   logic [ADDR_W-1:0] a1_q;
   logic [qbs_pkg::BURST_LEN-1:0][WORD_W-1:0] buf_q;

   assign rd_go     = ready && !rd_n && !s1_q;
   assign look      = s1_q;
   assign look_addr = a1_q;

   // stage 1: request held; stage 2: array words latched;
   // then two output cycles of two half-words each
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q     <= 1'b0;
         s2_q     <= 1'b0;
         s3_q     <= 1'b0;
         a1_q     <= '0;
         buf_q    <= '0;
         rq_r     <= '0;
         rq_f     <= '0;
         rq_valid <= 1'b0;
         rq_oe    <= 1'b0;
         echo_ph  <= qbs_pkg::ECHO_IDLE;
      end else begin
         s1_q <= rd_go;
         s2_q <= s1_q;
         s3_q <= s2_q;
         if (rd_go) begin
            a1_q <= addr;
         end
         if (s1_q) begin
            buf_q <= words;
         end
         if (s2_q) begin
            rq_r     <= buf_q[0];
            rq_f     <= buf_q[1];
            rq_valid <= 1'b1;
            rq_oe    <= 1'b1;
            echo_ph  <= qbs_pkg::ECHO_RUN;
         end else if (s3_q) begin
            rq_r     <= buf_q[2];
            rq_f     <= buf_q[3];
            rq_valid <= 1'b1;
            rq_oe    <= 1'b1;
            echo_ph  <= qbs_pkg::ECHO_RUN;
         end else begin
            rq_r     <= '0;
            rq_f     <= '0;
            rq_valid <= 1'b0;
            rq_oe    <= 1'b0;
            echo_ph  <= qbs_pkg::ECHO_IDLE;
         end
      end
   end

   // an accepted read drives data two edges later (seen at the third)
   p_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |-> ##3 rq_oe);
   // every burst lasts at least two output cycles
   p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rq_oe) |=> rq_oe);
   p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rq_oe |-> (rq_r == '0 && rq_f == '0));
   p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> rq_oe);
   p_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rq_oe |-> (echo_ph == 2'b10));
endmodule

// File: rtl/qdr_burst_sram.sv
`timescale 1ns/1ps
module qdr_burst_sram #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned WORD_W   = 18,
   parameter int unsigned BYTES    = 2,
   parameter int unsigned LOCK_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wd_r,
   input  logic [WORD_W-1:0] wd_f,
   input  logic [BYTES-1:0]  be_r_n,
   input  logic [BYTES-1:0]  be_f_n,
   output logic              ready,
   output logic [WORD_W-1:0] rq_r,
   output logic [WORD_W-1:0] rq_f,
   output logic              rq_valid,
   output logic              rq_oe,
   output logic [1:0]        echo_ph
);
   localparam int unsigned NB = qbs_pkg::BURST_LEN;

   // configuration checks at elaboration
   generate
      if (BYTES == 0 || (WORD_W % BYTES) != 0) begin : g_bad_bytes
         $error("WORD_W must split evenly into BYTES");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W out of range 1..12");
      end
   endgenerate

   logic                        cm_we;
   logic [ADDR_W-1:0]           cm_addr;
   logic [NB-1:0][WORD_W-1:0]   cm_data;
   logic [NB-1:0][BYTES-1:0]    cm_be;
   logic                        look;
   logic [ADDR_W-1:0]           look_addr;
   logic [NB-1:0][WORD_W-1:0]   words;
   logic                        fwd;

   qbs_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (ready)
   );

   qbs_wr_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTES(BYTES)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready   (ready),
      .wr_n    (wr_n),
      .addr    (addr),
      .wd_r    (wd_r),
      .wd_f    (wd_f),
      .be_r_n  (be_r_n),
      .be_f_n  (be_f_n),
      .cm_we   (cm_we),
      .cm_addr (cm_addr),
      .cm_data (cm_data),
      .cm_be   (cm_be)
   );

   // the read samples the array on the same edge a same-cycle write commits
   assign fwd = look && cm_we && (look_addr == cm_addr);

   generate
      for (genvar k = 0; k < int'(NB); k++) begin : g_bank
         qbs_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTES(BYTES)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cm_we),
            .waddr (cm_addr),
            .wdata (cm_data[k]),
            .wbe   (cm_be[k]),
            .raddr (look_addr),
            .fwd   (fwd),
            .rword (words[k])
         );
      end
   endgenerate

   qbs_rd_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (ready),
      .rd_n      (rd_n),
      .addr      (addr),
      .words     (words),
      .look      (look),
      .look_addr (look_addr),
      .rq_r      (rq_r),
      .rq_f      (rq_f),
      .rq_valid  (rq_valid),
      .rq_oe     (rq_oe),
      .echo_ph   (echo_ph)
   );
endmodule

// File: tb/sim_qdr_burst_sram.sv
`timescale 1ns/1ps
module sim_qdr_burst_sram;
   localparam int AW   = 3;
   localparam int LOCK = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [17:0] wd_r = '0;
   logic [17:0] wd_f = '0;
   logic [1:0]  be_r_n = 2'b11;
   logic [1:0]  be_f_n = 2'b11;
   logic        ready;
   logic [17:0] rq_r, rq_f;
   logic        rq_valid, rq_oe;
   logic [1:0]  echo_ph;

   int n_chk = 0;
   int n_bad = 0;
   logic [17:0] mdl [0:7][0:3];
   logic [17:0] wv [0:3];
   logic [1:0]  mv [0:3];
   int          rlist [0:7];

   qdr_burst_sram #(.ADDR_W(AW), .WORD_W(18), .BYTES(2), .LOCK_CYC(LOCK)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wd_r(wd_r), .wd_f(wd_f), .be_r_n(be_r_n), .be_f_n(be_f_n),
      .ready(ready), .rq_r(rq_r), .rq_f(rq_f), .rq_valid(rq_valid),
      .rq_oe(rq_oe), .echo_ph(echo_ph)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [17:0] pat(input int a, input int k, input int s);
      return 18'((a * 37 + k * 11 + s * 101 + 5) * 263);
   endfunction

   task automatic apply(input int a);
      for (int k = 0; k < 4; k++)
         for (int b = 0; b < 2; b++)
            if (!mv[k][b]) mdl[a][k][b*9 +: 9] = wv[k][b*9 +: 9];
   endtask

   // write burst; junk=1 keeps wr_n low in the tail cycle (R6)
   task automatic wr_burst(input int a, input bit junk);
      apply(a);
      wr_n = 1'b0; addr = AW'(a);
      wd_r = wv[0]; wd_f = wv[1]; be_r_n = mv[0]; be_f_n = mv[1];
      step();
      wr_n = junk ? 1'b0 : 1'b1; addr = AW'(a ^ 5);
      wd_r = wv[2]; wd_f = wv[3]; be_r_n = mv[2]; be_f_n = mv[3];
      step();
      wr_n = 1'b1; be_r_n = 2'b11; be_f_n = 2'b11;
   endtask

   // n reads every second cycle; hold=1 also keeps rd_n low in between (R6)
   task automatic rd_stream(input int n, input bit hold, input string tag);
      for (int t = 0; t < 2 * n + 3; t++) begin
         if (t < 2 * n) begin
            if (t % 2 == 0) begin
               rd_n = 1'b0; addr = AW'(rlist[t / 2]);
            end else begin
               rd_n = hold ? 1'b0 : 1'b1; addr = AW'(rlist[t / 2] ^ 3);
            end
         end else begin
            rd_n = 1'b1;
         end
         step();
         if (t >= 2 && (t - 2) % 2 == 0 && (t - 2) / 2 < n) begin
            check(tag, {rq_r, rq_f}, {mdl[rlist[(t-2)/2]][0], mdl[rlist[(t-2)/2]][1]});
            check("R8", {34'd0, rq_oe, rq_valid}, 36'd3);
            check("R9", {34'd0, echo_ph}, 36'd2);
         end else if (t >= 3 && (t - 3) % 2 == 0 && (t - 3) / 2 < n) begin
            check(tag, {rq_r, rq_f}, {mdl[rlist[(t-3)/2]][2], mdl[rlist[(t-3)/2]][3]});
            check("R10", {35'd0, rq_oe}, 36'd1);
         end else begin
            check("R8", {rq_r, rq_f}, 36'd0);
            check("R8", {34'd0, rq_oe, rq_valid}, 36'd0);
            check("R9", {34'd0, echo_ph}, 36'd0);
         end
      end
   endtask

   // read and write of one address in the same cycle (R7)
   task automatic collide(input int a, input int s);
      for (int k = 0; k < 4; k++) begin
         wv[k] = pat(a, k, s);
         mv[k] = 2'((a * 3 + k + s) & 3);
      end
      apply(a);
      rd_n = 1'b0; wr_n = 1'b0; addr = AW'(a);
      wd_r = wv[0]; wd_f = wv[1]; be_r_n = mv[0]; be_f_n = mv[1];
      step();
      rd_n = 1'b1; wr_n = 1'b1;
      wd_r = wv[2]; wd_f = wv[3]; be_r_n = mv[2]; be_f_n = mv[3];
      step();
      be_r_n = 2'b11; be_f_n = 2'b11;
      step();
      check("R7", {rq_r, rq_f}, {mdl[a][0], mdl[a][1]});
      step();
      check("R7", {rq_r, rq_f}, {mdl[a][2], mdl[a][3]});
      step();
      check("R8", {34'd0, rq_oe, rq_valid}, 36'd0);
   endtask

   // read issued in the tail cycle of a write to the same address (R7)
   task automatic rd_in_tail(input int a, input int s);
      for (int k = 0; k < 4; k++) begin
         wv[k] = pat(a, k, s);
         mv[k] = 2'((a + 2 * k + s) & 3);
      end
      apply(a);
      wr_n = 1'b0; addr = AW'(a);
      wd_r = wv[0]; wd_f = wv[1]; be_r_n = mv[0]; be_f_n = mv[1];
      step();
      wr_n = 1'b1; rd_n = 1'b0;
      wd_r = wv[2]; wd_f = wv[3]; be_r_n = mv[2]; be_f_n = mv[3];
      step();
      rd_n = 1'b1; be_r_n = 2'b11; be_f_n = 2'b11;
      step();
      step();
      check("R7", {rq_r, rq_f}, {mdl[a][0], mdl[a][1]});
      step();
      check("R7", {rq_r, rq_f}, {mdl[a][2], mdl[a][3]});
      step();
   endtask

   initial begin
      // reset state (R2)
      repeat (3) step();
      check("R2", {rq_r, rq_f}, 36'd0);
      check("R2", {32'd0, rq_oe, rq_valid, echo_ph}, 36'd0);
      // lock count, reads requested throughout are ignored (R1)
      rd_n = 1'b0; addr = '0;
      @(negedge clk); rst_n = 1'b1;
      for (int i = 1; i <= LOCK; i++) begin
         step();
         check("R1", {35'd0, ready}, (i >= LOCK) ? 36'd1 : 36'd0);
         check("R1", {35'd0, rq_oe}, 36'd0);
      end
      rd_n = 1'b1;
      repeat (3) begin
         step();
         check("R1", {34'd0, rq_oe, ready}, 36'd1);
      end

      // fill every location with full enables (R4)
      for (int a = 0; a < 8; a++) begin
         for (int k = 0; k < 4; k++) begin
            wv[k] = pat(a, k, 0); mv[k] = 2'b00;
         end
         wr_burst(a, 1'b0);
      end
      rlist[0] = 6;
      rd_stream(1, 1'b0, "R3");
      for (int a = 0; a < 8; a++) rlist[a] = a;
      rd_stream(8, 1'b0, "R4");

      // byte-enable sweep (R5)
      for (int a = 0; a < 8; a++) begin
         for (int k = 0; k < 4; k++) begin
            wv[k] = pat(a, k, 1); mv[k] = 2'((a + k) & 3);
         end
         wr_burst(a, 1'b0);
      end
      for (int a = 0; a < 8; a++) rlist[a] = 7 - a;
      rd_stream(8, 1'b0, "R5");

      // second request in a busy cycle is dropped (R6)
      for (int k = 0; k < 4; k++) begin
         wv[k] = pat(2, k, 2); mv[k] = 2'b00;
      end
      wr_burst(2, 1'b1);
      rlist[0] = 7; rlist[1] = 2; rlist[2] = 5; rlist[3] = 0;
      rd_stream(4, 1'b1, "R6");

      // same-cycle and tail-cycle collisions (R7)
      for (int a = 0; a < 8; a++) collide(a, 3 + a);
      rd_in_tail(1, 20);
      rd_in_tail(6, 21);
      for (int a = 0; a < 8; a++) rlist[a] = (a * 5) % 8;
      rd_stream(8, 1'b1, "R7");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule